// File: doc/BRIEF.md
# Lane-Striped Vector Integer Arithmetic Unit

This block runs element-wise integer add and multiply over vector registers held in its own register file. The file is split into parallel lanes. Element `i` of every register lives in lane `i mod LANES`, at slot `i / LANES` inside that lane. For example, with the default eight lanes, lane 0 stores elements 0, 8, 16 and 24. Each lane owns a private slice of every register and a private pipelined arithmetic path. All lanes advance in lockstep, so one group of `LANES` elements enters the pipelines per cycle.

A host issues an instruction by pulsing `start_i` while `busy_o` is low. The instruction carries an opcode, two source register numbers, a destination register number and a requested vector length. Only elements 0 up to length-1 are computed and written. The other elements of the destination keep their values. When the last active element has been written back, `done_o` pulses for one cycle. A plain element write port and a combinational element read port let the host load operands and collect results. The write port is disabled while an instruction is in flight.

Top module: `vec_lane_unit`

## Requirements
- R1: With opcode 0 (add), each destination element `i` below the effective length becomes `(vs1[i] + vs2[i]) mod 2^32`.
- R2: With opcode 1 (multiply), each destination element `i` below the effective length becomes the low 32 bits of `vs1[i] * vs2[i]`.
- R3: Destination elements at or above the effective length keep their previous values.
- R4: A length of 0 raises `done_o` in the cycle after acceptance, keeps `busy_o` low and writes no element.
- R5: A requested length above 32 is treated as 32.
- R6: For a nonzero effective length L, `busy_o` is high from the edge that accepts the instruction until `ceil(L/8) + 5` edges later. At that edge `busy_o` falls and `done_o` rises for exactly one cycle. `done_o` and `busy_o` are never high together.
- R7: A `start_i` pulse while `busy_o` is high is ignored: no second instruction runs and its destination is untouched.
- R8: Element writes from the host while `busy_o` is high are ignored.
- R9: A destination equal to a source register yields the same result as distinct registers, because each element is read before it is overwritten.
- R10: An element written through the host port while idle can be read back on the combinational read port from the next cycle on. The element number selects lane `idx mod 8` and slot `idx / 8`.
- R11: A new instruction may be started in the cycle where `done_o` is high, and it runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Issue request, taken when `busy_o` is low |
| op_i | input | 1 | 0 = add, 1 = multiply |
| vd_i | input | 3 | Destination register number |
| vs1_i | input | 3 | First source register number |
| vs2_i | input | 3 | Second source register number |
| vlen_i | input | 6 | Requested vector length (clamped to 32) |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | One-cycle completion pulse |
| hw_en_i | input | 1 | Host element write enable |
| hw_reg_i | input | 3 | Host write register number |
| hw_idx_i | input | 5 | Host write element number |
| hw_data_i | input | 32 | Host write data |
| hr_reg_i | input | 3 | Host read register number |
| hr_idx_i | input | 5 | Host read element number |
| hr_data_o | output | 32 | Host read data (combinational) |

## Verification
The embedded properties check the following on every cycle:
- `done_o` stays a single pulse.
- `done_o` and `busy_o` never overlap.
- A falling `busy_o` always comes with `done_o`.
- A zero length completes at once.
- The latched instruction does not change while busy.
- A pipeline writeback never meets a host write.

The arithmetic results, the untouched tail above the length, the clamp, in-place operation and back-to-back issue can only be shown by the bench scenarios. These compare register contents, read through the host port, against a behavioural model. The same model also predicts `busy_o` and `done_o` for every clock.

// File: rtl/vlu_pkg.sv
// Package: shared types for the lane-striped vector unit.
// Assumes: opcode encoding is fixed at one bit (0 add, 1 multiply).
package vlu_pkg;

    typedef enum logic {
        VOP_ADD = 1'b0,
        VOP_MUL = 1'b1
    } vop_e;

endpackage

// File: rtl/vlu_ctrl.sv
// Module: vlu_ctrl
// Sequences one vector instruction: latches the operands, clamps the length,
// steps a group counter that drives all lanes in lockstep, and raises done
// once the last group has left the pipeline.
// Assumes: VLMAX is a multiple of LANES, VLMAX/LANES >= 2, DEPTH >= 2.
module vlu_ctrl
    import vlu_pkg::*;
#(
    parameter int LANES = 8,
    parameter int VLMAX = 32,
    parameter int NREGS = 8,
    parameter int DEPTH = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           op_i,
    input  logic [$clog2(NREGS)-1:0]       vd_i,
    input  logic [$clog2(NREGS)-1:0]       vs1_i,
    input  logic [$clog2(NREGS)-1:0]       vs2_i,
    input  logic [$clog2(VLMAX):0]         vlen_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic [$clog2(VLMAX/LANES)-1:0] slot_o,
    output logic [LANES-1:0]               act_o,
    output vop_e                           op_o,
    output logic [$clog2(NREGS)-1:0]       vd_o,
    output logic [$clog2(NREGS)-1:0]       vs1_o,
    output logic [$clog2(NREGS)-1:0]       vs2_o
);

    localparam int SLOTS  = VLMAX / LANES;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LEN_W  = $clog2(VLMAX) + 1;
    localparam int REG_W  = $clog2(NREGS);
    localparam int CNT_W  = $clog2(SLOTS + DEPTH) + 1;

    logic              busy_q, done_q;
    logic [CNT_W-1:0]  cnt_q, grp_q, grp_in;
    logic [LEN_W-1:0]  len_q, len_cl;
    vop_e              op_q;
    logic [REG_W-1:0]  vd_q, vs1_q, vs2_q;
    logic              accept, issue, finish;

    // Clamp the requested length and derive the number of element groups.
    always_comb begin
        len_cl = (vlen_i > LEN_W'(VLMAX)) ? LEN_W'(VLMAX) : vlen_i;
        grp_in = CNT_W'((int'(len_cl) + LANES - 1) / LANES);
    end

    // Decode acceptance, the issue window and the final writeback cycle.
    always_comb begin
        accept = start_i && !busy_q;
        issue  = busy_q && (cnt_q < grp_q);
        finish = busy_q && (int'(cnt_q) == int'(grp_q) + DEPTH - 2);
    end

    // Per-lane activity: element (group*LANES + lane) must be below the length.
    for (genvar l = 0; l < LANES; l++) begin : g_act
        assign act_o[l] = issue && ((int'(cnt_q) * LANES + l) < int'(len_q));
    end

    // Instruction state: latch on accept, count groups, finish after drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            grp_q  <= '0;
            len_q  <= '0;
            op_q   <= VOP_ADD;
            vd_q   <= '0;
            vs1_q  <= '0;
            vs2_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                len_q <= len_cl;
                grp_q <= grp_in;
                op_q  <= vop_e'(op_i);
                vd_q  <= vd_i;
                vs1_q <= vs1_i;
                vs2_q <= vs2_i;
                cnt_q <= '0;
                if (len_cl == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign slot_o = cnt_q[SLOT_W-1:0];
    assign op_o   = op_q;
    assign vd_o   = vd_q;
    assign vs1_o  = vs1_q;
    assign vs2_o  = vs2_q;

    // Done is a single pulse unless another zero-length start follows it.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> !done_q);

    // Busy and done never overlap.
    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));

    // A start seen while busy leaves the latched instruction alone.
    assert_busy_holds_instr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(len_q) && $stable(vd_q) && $stable(op_q)));

endmodule

// File: rtl/vlu_lane.sv
// Module: vlu_lane
// One lane: holds slot (idx / LANES) of every vector register for the
// elements with idx mod LANES == LANE_ID, and runs a DEPTH-stage arithmetic
// pipeline (DEPTH-1 registered stages plus the writeback edge).
// Assumes: the host write enable is already blocked while busy, so it never
// collides with a pipeline writeback.
module vlu_lane
    import vlu_pkg::*;
#(
    parameter int LANE_ID = 0,
    parameter int LANES   = 8,
    parameter int VLMAX   = 32,
    parameter int NREGS   = 8,
    parameter int ELEM_W  = 32,
    parameter int DEPTH   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           act_i,
    input  logic [$clog2(VLMAX/LANES)-1:0] slot_i,
    input  vop_e                           op_i,
    input  logic [$clog2(NREGS)-1:0]       vd_i,
    input  logic [$clog2(NREGS)-1:0]       vs1_i,
    input  logic [$clog2(NREGS)-1:0]       vs2_i,
    input  logic                           hw_we_i,
    input  logic [$clog2(NREGS)-1:0]       hw_reg_i,
    input  logic [$clog2(VLMAX/LANES)-1:0] hw_slot_i,
    input  logic [ELEM_W-1:0]              hw_data_i,
    input  logic [$clog2(NREGS)-1:0]       hr_reg_i,
    input  logic [$clog2(VLMAX/LANES)-1:0] hr_slot_i,
    output logic [ELEM_W-1:0]              hr_data_o
);

    localparam int SLOTS  = VLMAX / LANES;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int STG    = DEPTH - 1;

    logic [ELEM_W-1:0] rf [NREGS][SLOTS];
    logic [ELEM_W-1:0] opa, opb, res;
    logic [STG-1:0]    vld_q;
    logic [ELEM_W-1:0] dat_q [STG];
    logic [SLOT_W-1:0] slt_q [STG];

    // Operand fetch for the group being issued and the element result.
    always_comb begin
        opa = rf[vs1_i][slot_i];
        opb = rf[vs2_i][slot_i];
        res = (op_i == VOP_MUL) ? (opa * opb) : (opa + opb);
    end

    // Valid bits of the pipeline, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= act_i;
            for (int s = 1; s < STG; s++) begin
                vld_q[s] <= vld_q[s-1];
            end
        end
    end

    // Result and slot payload shifting alongside the valid bits.
    always_ff @(posedge clk) begin
        dat_q[0] <= res;
        slt_q[0] <= slot_i;
        for (int s = 1; s < STG; s++) begin
            dat_q[s] <= dat_q[s-1];
            slt_q[s] <= slt_q[s-1];
        end
    end

    // Register slice write: pipeline writeback, else host write.
    always_ff @(posedge clk) begin
        if (vld_q[STG-1]) begin
            rf[vd_i][slt_q[STG-1]] <= dat_q[STG-1];
        end else if (hw_we_i) begin
            rf[hw_reg_i][hw_slot_i] <= hw_data_i;
        end
    end

    assign hr_data_o = rf[hr_reg_i][hr_slot_i];

    // Host writes are blocked while busy, so they never meet a writeback.
    assert_wb_host_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q[STG-1] && hw_we_i));

endmodule

// File: rtl/vec_lane_unit.sv
// Module: vec_lane_unit (top)
// Element-wise vector add / multiply over a register file striped across
// LANES lockstep lanes. Hosts load and read elements through plain ports
// and issue one instruction at a time while busy is low.
// Assumes: LANES is a power of two and divides VLMAX; NREGS is a power of two.
module vec_lane_unit
    import vlu_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int VLMAX  = 32,
    parameter int NREGS  = 8,
    parameter int ELEM_W = 32,
    parameter int DEPTH  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     op_i,
    input  logic [$clog2(NREGS)-1:0] vd_i,
    input  logic [$clog2(NREGS)-1:0] vs1_i,
    input  logic [$clog2(NREGS)-1:0] vs2_i,
    input  logic [$clog2(VLMAX):0]   vlen_i,
    output logic                     busy_o,
    output logic                     done_o,
    input  logic                     hw_en_i,
    input  logic [$clog2(NREGS)-1:0] hw_reg_i,
    input  logic [$clog2(VLMAX)-1:0] hw_idx_i,
    input  logic [ELEM_W-1:0]        hw_data_i,
    input  logic [$clog2(NREGS)-1:0] hr_reg_i,
    input  logic [$clog2(VLMAX)-1:0] hr_idx_i,
    output logic [ELEM_W-1:0]        hr_data_o
);

    localparam int SLOTS  = VLMAX / LANES;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = $clog2(VLMAX);
    localparam int REG_W  = $clog2(NREGS);

    logic [SLOT_W-1:0] slot;
    logic [LANES-1:0]  act;
    vop_e              op_q;
    logic [REG_W-1:0]  vd_q, vs1_q, vs2_q;
    logic [LANES-1:0]  lane_we;
    logic [ELEM_W-1:0] lane_rd [LANES];
    logic [SLOT_W-1:0] hw_slot, hr_slot;
    logic [LANE_W-1:0] hw_lane, hr_lane;

    vlu_ctrl #(
        .LANES (LANES),
        .VLMAX (VLMAX),
        .NREGS (NREGS),
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_i),
        .vd_i    (vd_i),
        .vs1_i   (vs1_i),
        .vs2_i   (vs2_i),
        .vlen_i  (vlen_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .slot_o  (slot),
        .act_o   (act),
        .op_o    (op_q),
        .vd_o    (vd_q),
        .vs1_o   (vs1_q),
        .vs2_o   (vs2_q)
    );

    // Split host element numbers into lane (low bits) and slot (high bits).
    always_comb begin
        hw_lane = hw_idx_i[LANE_W-1:0];
        hw_slot = hw_idx_i[IDX_W-1:LANE_W];
        hr_lane = hr_idx_i[LANE_W-1:0];
        hr_slot = hr_idx_i[IDX_W-1:LANE_W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we[l] = hw_en_i && !busy_o && (hw_lane == LANE_W'(l));

        vlu_lane #(
            .LANE_ID (l),
            .LANES   (LANES),
            .VLMAX   (VLMAX),
            .NREGS   (NREGS),
            .ELEM_W  (ELEM_W),
            .DEPTH   (DEPTH)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act[l]),
            .slot_i    (slot),
            .op_i      (op_q),
            .vd_i      (vd_q),
            .vs1_i     (vs1_q),
            .vs2_i     (vs2_q),
            .hw_we_i   (lane_we[l]),
            .hw_reg_i  (hw_reg_i),
            .hw_slot_i (hw_slot),
            .hw_data_i (hw_data_i),
            .hr_reg_i  (hr_reg_i),
            .hr_slot_i (hr_slot),
            .hr_data_o (lane_rd[l])
        );
    end

    assign hr_data_o = lane_rd[hr_lane];

    // Busy only ends together with the completion pulse.
    assert_busy_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // A zero-length instruction completes at once without going busy.
    assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (vlen_i == '0)) |=> (done_o && !busy_o));

endmodule

// File: tb/vec_lane_unit_test.sv
// Bench: behavioural model of register contents and busy/done timing,
// compared on every falling clock edge and through host reads.
module vec_lane_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int VLMAX = 32;
    localparam int NREGS = 8;
    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [2:0]  vd_i = '0, vs1_i = '0, vs2_i = '0;
    logic [5:0]  vlen_i = '0;
    logic        busy_o, done_o;
    logic        hw_en_i = 1'b0;
    logic [2:0]  hw_reg_i = '0;
    logic [4:0]  hw_idx_i = '0;
    logic [31:0] hw_data_i = '0;
    logic [2:0]  hr_reg_i = '0;
    logic [4:0]  hr_idx_i = '0;
    logic [31:0] hr_data_o;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    // Model state
    logic [31:0] mdl [NREGS][VLMAX];
    bit  eb = 0, ed = 0, was_busy;
    int  cnt = 0, len_c, p_len;
    bit  p_op;
    int  p_vd, p_s1, p_s2;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .vd_i(vd_i), .vs1_i(vs1_i), .vs2_i(vs2_i), .vlen_i(vlen_i),
        .busy_o(busy_o), .done_o(done_o),
        .hw_en_i(hw_en_i), .hw_reg_i(hw_reg_i), .hw_idx_i(hw_idx_i), .hw_data_i(hw_data_i),
        .hr_reg_i(hr_reg_i), .hr_idx_i(hr_idx_i), .hr_data_o(hr_data_o)
    );

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            eb = 0; ed = 0; cnt = 0;
        end else begin
            was_busy = eb;
            ed = 0;
            if (eb) begin
                cnt--;
                if (cnt == 0) begin
                    eb = 0; ed = 1;
                    for (int i = 0; i < p_len; i++) begin
                        if (p_op) mdl[p_vd][i] = mdl[p_s1][i] * mdl[p_s2][i];
                        else      mdl[p_vd][i] = mdl[p_s1][i] + mdl[p_s2][i];
                    end
                end
            end
            if (!was_busy) begin
                if (hw_en_i) mdl[hw_reg_i][hw_idx_i] = hw_data_i;
                if (start_i) begin
                    len_c = (int'(vlen_i) > VLMAX) ? VLMAX : int'(vlen_i);
                    if (len_c == 0) begin
                        ed = 1;
                    end else begin
                        eb = 1; p_len = len_c; p_op = op_i;
                        p_vd = int'(vd_i); p_s1 = int'(vs1_i); p_s2 = int'(vs2_i);
                        cnt = (len_c + LANES - 1) / LANES + DEPTH - 1;
                    end
                end
            end
        end
    end

    // Per-clock comparison of busy/done (R6, R4, R11).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (busy_o !== eb || done_o !== ed) begin
                fails++;
                $display("FAIL R6 timing at cycle %0d: busy/done %b%b expected %b%b",
                         cyc, busy_o, done_o, eb, ed);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            fails++;
            finished = 1;
            $display("FAIL watchdog expired: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic host_write(input int r, input int idx, input logic [31:0] d);
        @(negedge clk);
        hw_en_i = 1; hw_reg_i = 3'(r); hw_idx_i = 5'(idx); hw_data_i = d;
        @(negedge clk);
        hw_en_i = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (eb || ed || busy_o || done_o) @(negedge clk);
    endtask

    task automatic issue(input bit o, input int d, input int s1, input int s2, input int len);
        @(negedge clk);
        start_i = 1; op_i = o; vd_i = 3'(d); vs1_i = 3'(s1); vs2_i = 3'(s2); vlen_i = 6'(len);
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic check_reg(input int r, input string tag);
        for (int i = 0; i < VLMAX; i++) begin
            hr_reg_i = 3'(r); hr_idx_i = 5'(i);
            #1;
            vectors++;
            if (hr_data_o !== mdl[r][i]) begin
                fails++;
                $display("FAIL %s reg %0d elem %0d: got %h expected %h",
                         tag, r, i, hr_data_o, mdl[r][i]);
            end
        end
    endtask

    initial begin
        for (int r = 0; r < NREGS; r++)
            for (int i = 0; i < VLMAX; i++) mdl[r][i] = '0;
        repeat (3) @(negedge clk);
        // Reset state check
        vectors++;
        if (busy_o !== 1'b0 || done_o !== 1'b0) begin
            fails++;
            $display("FAIL R6 reset: busy/done %b%b expected 00", busy_o, done_o);
        end
        rst_n = 1;

        // R10: load every register through the host port
        for (int r = 0; r < NREGS; r++)
            for (int i = 0; i < VLMAX; i++)
                host_write(r, i, 32'hF000_0000 + 32'(i) * 32'h0123_4567 + 32'(r) * 32'h1357_9BDF);
        for (int r = 0; r < NREGS; r++) check_reg(r, "R10 load");

        // R1: full-length add with wraparound
        issue(0, 3, 1, 2, 32); wait_idle(); check_reg(3, "R1 add");
        // R2: full-length multiply, low 32 bits
        issue(1, 4, 1, 2, 32); wait_idle(); check_reg(4, "R2 mul");
        // R3: partial length 13, tail untouched
        issue(1, 3, 5, 6, 13); wait_idle(); check_reg(3, "R3 tail");
        // R3: length 1
        issue(0, 4, 6, 7, 1); wait_idle(); check_reg(4, "R3 len1");
        // R4: zero length writes nothing
        issue(0, 5, 1, 2, 0); wait_idle(); check_reg(5, "R4 zero");
        // R5: length 40 clamps to 32
        issue(0, 5, 3, 4, 40); wait_idle(); check_reg(5, "R5 clamp");
        // R9: destination equals a source
        issue(1, 1, 1, 2, 29); wait_idle(); check_reg(1, "R9 inplace");
        issue(0, 2, 2, 2, 32); wait_idle(); check_reg(2, "R9 self");

        // R7: second start while busy is ignored
        issue(1, 6, 3, 4, 32);
        @(negedge clk);
        start_i = 1; op_i = 0; vd_i = 3'd7; vs1_i = 3'd1; vs2_i = 3'd2; vlen_i = 6'd32;
        @(negedge clk);
        start_i = 0;
        // R8: host write during busy is ignored
        hw_en_i = 1; hw_reg_i = 3'd0; hw_idx_i = 5'd3; hw_data_i = 32'hDEAD_BEEF;
        @(negedge clk);
        hw_en_i = 0;
        wait_idle();
        check_reg(6, "R7 first");
        check_reg(7, "R7 ignored");
        check_reg(0, "R8 blocked");

        // R11: start issued in the done cycle
        issue(0, 7, 5, 6, 17);
        @(negedge clk);
        while (!done_o) @(negedge clk);
        start_i = 1; op_i = 1; vd_i = 3'd0; vs1_i = 3'd7; vs2_i = 3'd3; vlen_i = 6'd24;
        @(negedge clk);
        start_i = 0;
        wait_idle();
        check_reg(7, "R11 first");
        check_reg(0, "R11 second");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule